// File: doc/BRIEF.md
# CAN Transmit Frame Staging Queue

This block sits between a register write port and a CAN transmit engine. Software builds an outgoing frame by writing four 32-bit words into staging registers: identifier, length code, first data word and second data word. One particular write commits the staged frame as a single entry into a FIFO of parameterised depth. For a remote frame the commit write is the length code write. For a data frame it is the second data word write. The staging registers are never cleared. To send a frame that differs from the previous one in a single field, software rewrites that field and then the commit word.

A handoff state machine offers the oldest entry to the engine over a valid/ready pair. It holds exactly one frame in flight. It waits for the engine's sent pulse before it offers the next entry, and it converts that pulse into a transmit-ok event. A status word reports the full condition. Two one-cycle events mark the queue becoming full and the last entry leaving it. The handoff machine has three states:

- HO_IDLE: nothing is offered.
- HO_OFFER: `tx_valid` is high and the head entry is on `tx_id`/`tx_len`/`tx_dw1`/`tx_dw2`.
- HO_BUSY: the engine owns a frame.

Its transitions are:

- HO_IDLE to HO_OFFER when the queue is non-empty.
- HO_OFFER to HO_BUSY on a handshake.
- HO_BUSY to HO_OFFER on `tx_sent` when entries remain.
- HO_BUSY to HO_IDLE on `tx_sent` when the queue is empty.

Top module: `can_txs`

## Requirements
- R1: `wr_addr` is a byte offset. Writes land in the identifier register at 0x30, the length register at 0x34 (code taken from bits [31:28]), data word 1 at 0x38 and data word 2 at 0x3C. A write to any other offset changes no staging register and commits nothing.
- R2: The identifier word carries the base identifier in [31:21], the standard remote flag in bit 20, the extension flag in bit 19, the extended identifier in [18:1] and the extended remote flag in bit 0. A frame is remote when bit 19 is clear and bit 20 is set, or when bit 19 is set and bit 0 is set. A data frame is committed by the write to 0x3C. Its entry holds the staged identifier, length and data word 1, plus the written data word 2.
- R3: A remote frame is committed by the write to 0x34. Its entry holds the staged identifier and the written length code, with both data words zero.
- R4: A write to 0x34 while a data frame is staged commits nothing. A write to 0x3C while a remote frame is staged commits nothing.
- R5: Staging registers keep their contents after a commit or a drop. Rewriting only the commit word commits a new frame built from the retained fields.
- R6: Entries leave in commit order, one per `tx_valid`/`tx_ready` handshake. The default depth is 4.
- R7: `status` bit 10 is 1 exactly while the queue holds DEPTH entries, and all other status bits read 0. `evt_full` pulses for one cycle in the first cycle the queue is full.
- R8: A commit while the queue is full is dropped, and the queued entries are unchanged.
- R9: `tx_valid` rises one cycle after the queue becomes non-empty in HO_IDLE. It holds the head stable until `tx_ready`, and it stays low in HO_BUSY.
- R10: `tx_sent` in HO_BUSY gives a one-cycle `tx_ok` pulse in the following cycle. `tx_sent` in any other state is ignored.
- R11: `evt_empty` pulses for one cycle in the cycle after the handshake that removes the last entry.
- R12: After reset the queue is empty, and `tx_valid`, `tx_ok`, `evt_full`, `evt_empty` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte offset |
| wr_data | input | 32 | Register write data |
| tx_valid | output | 1 | Head frame offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered frame |
| tx_id | output | 32 | Identifier word of the offered frame |
| tx_len | output | 4 | Length code of the offered frame |
| tx_dw1 | output | 32 | Data word 1 of the offered frame |
| tx_dw2 | output | 32 | Data word 2 of the offered frame |
| tx_sent | input | 1 | Engine finished the frame it holds |
| tx_ok | output | 1 | Transmit-ok event |
| evt_full | output | 1 | Queue-became-full event |
| evt_empty | output | 1 | Last-entry-removed event |
| status | output | 32 | Status word, bit 10 = queue full |

## Verification
A commit write sampled at one clock edge is counted in `status` right after that edge. `evt_full` appears in that same cycle. `tx_valid` follows one edge later. A handshake at an edge drops `tx_valid` and raises `evt_empty` right after that edge. `tx_sent` at an edge raises `tx_ok` right after it. The bench drives every input at the falling edge and reads every output at a later falling edge, counted exactly from those edges. The engine model in the bench compares each offered frame against the scoreboard queue at the falling edge before the accepting rising edge.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;

    localparam logic [7:0] TXS_OFS_ID  = 8'h30;
    localparam logic [7:0] TXS_OFS_LEN = 8'h34;
    localparam logic [7:0] TXS_OFS_DW1 = 8'h38;
    localparam logic [7:0] TXS_OFS_DW2 = 8'h3C;

    localparam int TXS_STAT_FULL_BIT = 10;
    localparam int TXS_LEN_MSB       = 31;
    localparam int TXS_LEN_LSB       = 28;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  len;
        logic [31:0] dw1;
        logic [31:0] dw2;
    } txs_frame_t;

    localparam int TXS_FRAME_W = $bits(txs_frame_t);

    typedef enum logic [1:0] {
        HO_IDLE  = 2'd0,
        HO_OFFER = 2'd1,
        HO_BUSY  = 2'd2
    } txs_ho_state_e;

    // Bit 19 selects which flag marks a remote frame.
    function automatic logic txs_is_remote(input logic [31:0] id_word);
        return id_word[19] ? id_word[0] : id_word[20];
    endfunction

endpackage

// File: rtl/can_txs_stage.sv
module can_txs_stage
    import can_txs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              commit_o,
    output txs_frame_t        frame_o
);

    logic [31:0] id_q;
    logic [3:0]  len_q;
    logic [31:0] dw1_q;
    logic [31:0] dw2_q;

    logic hit_id, hit_len, hit_dw1, hit_dw2;
    logic staged_remote;

    always_comb begin
        hit_id  = wr_en && (wr_addr == ADDR_W'(TXS_OFS_ID));
        hit_len = wr_en && (wr_addr == ADDR_W'(TXS_OFS_LEN));
        hit_dw1 = wr_en && (wr_addr == ADDR_W'(TXS_OFS_DW1));
        hit_dw2 = wr_en && (wr_addr == ADDR_W'(TXS_OFS_DW2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q  <= '0;
            len_q <= '0;
            dw1_q <= '0;
            dw2_q <= '0;
        end else begin
            if (hit_id)  id_q  <= wr_data;
            if (hit_len) len_q <= wr_data[TXS_LEN_MSB:TXS_LEN_LSB];
            if (hit_dw1) dw1_q <= wr_data;
            if (hit_dw2) dw2_q <= wr_data;
        end
    end

    // The commit word is built from the write in flight, not the register.
    always_comb begin
        staged_remote = txs_is_remote(id_q);
        commit_o      = staged_remote ? hit_len : hit_dw2;
        frame_o.id    = id_q;
        frame_o.len   = hit_len ? wr_data[TXS_LEN_MSB:TXS_LEN_LSB] : len_q;
        frame_o.dw1   = staged_remote ? 32'h0 : dw1_q;
        frame_o.dw2   = staged_remote ? 32'h0 : (hit_dw2 ? wr_data : dw2_q);
    end

endmodule

// File: rtl/can_txs_fifo.sv
module can_txs_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 100
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push_i,
    input  logic [WIDTH-1:0]                 data_i,
    input  logic                             pop_i,
    output logic [WIDTH-1:0]                 data_o,
    output logic [$clog2(DEPTH+1)-1:0]       cnt_o,
    output logic                             full_o,
    output logic                             last_pop_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [PTR_W-1:0] wr_ptr_nxt, rd_ptr_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             accept, take;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_ptr_pow2
            assign wr_ptr_nxt = wr_ptr_q + PTR_W'(1);
            assign rd_ptr_nxt = rd_ptr_q + PTR_W'(1);
        end else begin : g_ptr_wrap
            assign wr_ptr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
            assign rd_ptr_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
        end
    endgenerate

    always_comb begin
        full_o     = (cnt_q == CNT_W'(DEPTH));
        accept     = push_i && !full_o;
        take       = pop_i && (cnt_q != '0);
        last_pop_o = take && !accept && (cnt_q == CNT_W'(1));
        cnt_o      = cnt_q;
        data_o     = mem_q[rd_ptr_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (accept) wr_ptr_q <= wr_ptr_nxt;
            if (take)   rd_ptr_q <= rd_ptr_nxt;
            unique case ({accept, take})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[wr_ptr_q] <= data_i;
    end

endmodule

// File: rtl/can_txs_ctrl.sv
module can_txs_ctrl
    import can_txs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic avail_i,
    input  logic full_i,
    input  logic last_pop_i,
    input  logic tx_ready_i,
    input  logic tx_sent_i,
    output logic tx_valid_o,
    output logic pop_o,
    output logic tx_ok_o,
    output logic evt_empty_o,
    output logic evt_full_o
);

    txs_ho_state_e state_q, state_d;
    logic          sent_hit;
    logic          full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HO_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HO_IDLE:  if (avail_i)    state_d = HO_OFFER;
            HO_OFFER: if (tx_ready_i) state_d = HO_BUSY;
            HO_BUSY:  if (tx_sent_i)  state_d = avail_i ? HO_OFFER : HO_IDLE;
            default:                  state_d = HO_IDLE;
        endcase
    end

    always_comb begin
        tx_valid_o = (state_q == HO_OFFER);
        pop_o      = tx_valid_o && tx_ready_i;
        sent_hit   = (state_q == HO_BUSY) && tx_sent_i;
        evt_full_o = full_i && !full_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ok_o     <= 1'b0;
            evt_empty_o <= 1'b0;
            full_q      <= 1'b0;
        end else begin
            tx_ok_o     <= sent_hit;
            evt_empty_o <= last_pop_i;
            full_q      <= full_i;
        end
    end

endmodule

// File: rtl/can_txs.sv
module can_txs
    import can_txs_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_id,
    output logic [3:0]        tx_len,
    output logic [31:0]       tx_dw1,
    output logic [31:0]       tx_dw2,
    input  logic              tx_sent,
    output logic              tx_ok,
    output logic              evt_full,
    output logic              evt_empty,
    output logic [31:0]       status
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             commit;
    txs_frame_t       stage_frame;
    txs_frame_t       head_frame;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_full;
    logic             last_pop;
    logic             pop;

    can_txs_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit_o (commit),
        .frame_o  (stage_frame)
    );

    can_txs_fifo #(.DEPTH(DEPTH), .WIDTH(TXS_FRAME_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (commit),
        .data_i     (stage_frame),
        .pop_i      (pop),
        .data_o     (head_frame),
        .cnt_o      (fifo_cnt),
        .full_o     (fifo_full),
        .last_pop_o (last_pop)
    );

    can_txs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .avail_i     (fifo_cnt != '0),
        .full_i      (fifo_full),
        .last_pop_i  (last_pop),
        .tx_ready_i  (tx_ready),
        .tx_sent_i   (tx_sent),
        .tx_valid_o  (tx_valid),
        .pop_o       (pop),
        .tx_ok_o     (tx_ok),
        .evt_empty_o (evt_empty),
        .evt_full_o  (evt_full)
    );

    always_comb begin
        tx_id  = head_frame.id;
        tx_len = head_frame.len;
        tx_dw1 = head_frame.dw1;
        tx_dw2 = head_frame.dw2;
        status = '0;
        status[TXS_STAT_FULL_BIT] = fifo_full;
    end

endmodule

// File: rtl/can_txs_chk.sv
module can_txs_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tx_valid,
    input logic                       tx_ready,
    input logic [31:0]                tx_id,
    input logic                       tx_sent,
    input logic                       tx_ok,
    input logic                       evt_full,
    input logic                       evt_empty,
    input logic [31:0]                status,
    input logic [$clog2(DEPTH+1)-1:0] fill
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    // R8: a dropped commit never pushes the occupancy past the depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R6: an offer always has an entry behind it
    assert_offer_backed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> fill != '0);

    // R9: an unaccepted offer stays up with the same head
    assert_offer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_id));

    // R10: transmit-ok only follows a sent pulse taken while no offer was up
    assert_ok_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok |-> $past(tx_sent) && !$past(tx_valid));

    // R7: the full event marks the first full cycle only
    assert_full_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_full |-> status[10] && !$past(status[10]));

    // R11: the empty event follows a handshake and leaves nothing offered
    assert_empty_after_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_empty |-> $past(tx_valid && tx_ready) && !tx_valid);

endmodule

bind can_txs can_txs_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_id     (tx_id),
    .tx_sent   (tx_sent),
    .tx_ok     (tx_ok),
    .evt_full  (evt_full),
    .evt_empty (evt_empty),
    .status    (status),
    .fill      (fifo_cnt)
);

// File: tb/can_txs_tb_top.sv
module can_txs_tb_top;
    import can_txs_pkg::*;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_ready = 1'b0;
    logic        tx_sent = 1'b0;
    logic        tx_valid, tx_ok, evt_full, evt_empty;
    logic [31:0] tx_id, tx_dw1, tx_dw2, status;
    logic [3:0]  tx_len;

    always #4 clk = ~clk;

    can_txs #(.DEPTH(DEPTH), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id), .tx_len(tx_len),
        .tx_dw1(tx_dw1), .tx_dw2(tx_dw2), .tx_sent(tx_sent), .tx_ok(tx_ok),
        .evt_full(evt_full), .evt_empty(evt_empty), .status(status)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    int         model_cnt = 0;
    bit         eng_on = 1'b0;
    bit         eng_busy = 1'b0;
    txs_frame_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [99:0] act, input logic [99:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_commit(input txs_frame_t f);
        if (model_cnt < DEPTH) begin
            exp_q.push_back(f);
            model_cnt++;
        end
    endtask

    task automatic send(input logic [31:0] id, input logic [3:0] len,
                        input logic [31:0] d1, input logic [31:0] d2);
        txs_frame_t f;
        bit rem;
        rem = id[19] ? id[0] : id[20];
        f.id = id; f.len = len;
        f.dw1 = rem ? 32'h0 : d1;
        f.dw2 = rem ? 32'h0 : d2;
        wr(8'h30, id);
        if (rem) begin
            expect_commit(f);
            wr(8'h34, {len, 28'h0});
        end else begin
            wr(8'h34, {len, 28'h0});
            wr(8'h38, d1);
            expect_commit(f);
            wr(8'h3C, d2);
        end
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0 || eng_busy) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req, input string what);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, req, what, 100'(tx_valid), 100'(0));
        end
    endtask

    // Engine model and scoreboard monitor
    initial begin
        txs_frame_t e;
        bit last;
        forever begin
            @(negedge clk);
            tx_ready = eng_on;
            if (rst_n && tx_valid && tx_ready) begin
                eng_busy = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "frame offered with nothing expected",
                        {tx_id, tx_len, tx_dw1, tx_dw2}, 100'(0));
                    last = 1'b0;
                end else begin
                    e = exp_q.pop_front();
                    model_cnt--;
                    last = (model_cnt == 0);
                    chk({tx_id, tx_len, tx_dw1, tx_dw2} == e, "R6", "offered frame in order",
                        {tx_id, tx_len, tx_dw1, tx_dw2}, e);
                end
                @(negedge clk);
                tx_ready = 1'b0;
                chk(tx_valid == 1'b0, "R9", "no offer while busy", 100'(tx_valid), 100'(0));
                chk(evt_empty == last, "R11", "empty event after pop", 100'(evt_empty), 100'(last));
                @(negedge clk);
                tx_sent = 1'b1;
                @(negedge clk);
                tx_sent = 1'b0;
                chk(tx_ok == 1'b1, "R10", "tx ok after sent", 100'(tx_ok), 100'(1));
                @(negedge clk);
                chk(tx_ok == 1'b0, "R10", "tx ok one cycle", 100'(tx_ok), 100'(0));
                eng_busy = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        txs_frame_t f;
        // R12: reset state
        repeat (3) @(negedge clk);
        chk({tx_valid, tx_ok, evt_full, evt_empty} == 4'b0, "R12", "outputs in reset",
            100'({tx_valid, tx_ok, evt_full, evt_empty}), 100'(0));
        chk(status == 32'h0, "R12", "status in reset", 100'(status), 100'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid == 1'b0 && status == 32'h0, "R12", "idle after reset",
            100'({tx_valid, status}), 100'(0));

        // R10: sent pulse while idle is ignored
        tx_sent = 1'b1;
        @(negedge clk);
        tx_sent = 1'b0;
        chk(tx_ok == 1'b0, "R10", "sent ignored when idle", 100'(tx_ok), 100'(0));

        // R1: stray offsets neither commit nor touch staging
        wr(8'h30, 32'h2460_0000);
        wr(8'h34, 32'h8000_0000);
        wr(8'h38, 32'hA1A2_A3A4);
        wr(8'h40, 32'hDEAD_0001);
        wr(8'h48, 32'hDEAD_0002);
        wr(8'h4C, 32'hDEAD_0003);
        wr(8'h20, 32'hDEAD_0004);
        quiet(2, "R1", "stray offset committed");
        f.id = 32'h2460_0000; f.len = 4'h8; f.dw1 = 32'hA1A2_A3A4; f.dw2 = 32'hB1B2_B3B4;
        expect_commit(f);
        wr(8'h3C, 32'hB1B2_B3B4);
        // R9: offer appears one cycle after the entry lands
        chk(tx_valid == 1'b0, "R9", "offer not yet up", 100'(tx_valid), 100'(0));
        @(negedge clk);
        chk(tx_valid == 1'b1, "R9", "offer up one cycle later", 100'(tx_valid), 100'(1));
        eng_on = 1'b1;
        wait_drain();
        eng_on = 1'b0;

        // R2: standard data frame through the full sequence
        send(32'h0246_0000, 4'h5, 32'h1111_2222, 32'h3333_4444);
        eng_on = 1'b1; wait_drain(); eng_on = 1'b0;

        // R3: standard remote frame commits on the length write, data zeroed
        send(32'hAAB0_0000, 4'h2, 32'h0, 32'h0);
        @(negedge clk);
        chk(tx_valid == 1'b1, "R3", "remote committed by length write", 100'(tx_valid), 100'(1));
        eng_on = 1'b1; wait_drain(); eng_on = 1'b0;
        // R4: word 2 write with a remote frame staged commits nothing
        wr(8'h3C, 32'h9999_9999);
        quiet(2, "R4", "word 2 committed a remote frame");

        // R4: extended data frame, length write does not commit
        wr(8'h30, 32'h1238_ACE6);
        wr(8'h34, 32'h7000_0000);
        quiet(2, "R4", "length write committed a data frame");
        wr(8'h38, 32'h0102_0304);
        f.id = 32'h1238_ACE6; f.len = 4'h7; f.dw1 = 32'h0102_0304; f.dw2 = 32'h0506_0708;
        expect_commit(f);
        wr(8'h3C, 32'h0506_0708);
        eng_on = 1'b1; wait_drain(); eng_on = 1'b0;

        // R3: extended remote frame
        send(32'h4FF8_1235, 4'h6, 32'h0, 32'h0);
        eng_on = 1'b1; wait_drain(); eng_on = 1'b0;

        // R7: fill to the depth
        for (int i = 0; i < DEPTH; i++) begin
            send(32'(i + 1) << 21, 4'(i), 32'hC0DE_0000 + 32'(i), 32'hF00D_0000 + 32'(i));
            if (i == DEPTH - 2)
                chk(status == 32'h0, "R7", "not full yet", 100'(status), 100'(0));
        end
        chk(status == 32'h0000_0400, "R7", "full flag at bit 10", 100'(status), 100'(32'h400));
        chk(evt_full == 1'b1, "R7", "full event", 100'(evt_full), 100'(1));
        @(negedge clk);
        chk(evt_full == 1'b0, "R7", "full event one cycle", 100'(evt_full), 100'(0));
        chk(tx_valid == 1'b1, "R9", "offer held without ready", 100'(tx_valid), 100'(1));

        // R8: commit while full is dropped
        send(32'h00C0_0000, 4'h3, 32'h5555_0001, 32'h5555_0002);
        chk(status == 32'h0000_0400, "R8", "still full after drop", 100'(status), 100'(32'h400));
        eng_on = 1'b1; wait_drain(); eng_on = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b0 && status == 32'h0, "R8", "dropped frame absent",
            100'({tx_valid, status}), 100'(0));

        // R5: retained fields plus a rewritten commit word
        f.id = 32'h00C0_0000; f.len = 4'h3; f.dw1 = 32'h5555_0001; f.dw2 = 32'h7777_0003;
        expect_commit(f);
        wr(8'h3C, 32'h7777_0003);
        expect_commit(f);
        wr(8'h3C, 32'h7777_0003);
        eng_on = 1'b1; wait_drain(); eng_on = 1'b0;

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "scoreboard drained", 100'(exp_q.size()), 100'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule